// File: doc/BRIEF.md
# Two-Wire Register Slave with Time Snapshot

This block is the serial front end of a timekeeping macro. It answers on a standard-mode two-wire (I2C) bus under a fixed 7-bit device address. Behind it sits a 64-byte register space. The lowest eight bytes belong to the timekeeper's clock and control registers, and the remaining 56 bytes are plain RAM held inside the block. The bus master first writes a one-byte word pointer. It then either streams data bytes into successive locations or opens a read and pulls bytes out until it declines one.

The timekeeper keeps its live registers outside this block. It presents them on a flat parallel bus and accepts writes through a one-cycle strobe that carries a 3-bit index and a byte. Every START, and every repeated START, freezes a private copy of the live bus. Clock-register reads are served from that copy, so a multi-byte read never mixes two different seconds. A power-fail input abandons the current transfer, returns the pointer to zero and deafens the slave for as long as it stays high.

SCL and SDA are sampled in the system clock domain through synchronizers. The system clock must run at least 20 times faster than SCL. The SDA output is an active-high pull-down enable that drives an external open-drain pad.

Top module: `i2c_regslave`

## Requirements
- R1: A first byte whose upper seven bits equal 1101000 is acknowledged, and bit 0 of that byte selects read (1) or write (0). Any other address is not acknowledged, and SDA stays released for every later bit until the next START or STOP.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START always restarts address reception. After a STOP the slave is idle with SDA released. The word pointer survives a STOP.
- R3: In a write transaction the byte after the address loads the 6-bit word pointer from its low six bits. Each later byte is stored at the pointer, and the pointer then advances. The slave acknowledges the pointer byte and every data byte.
- R4: In a read transaction the slave sends bytes MSB first, starting at the current pointer and advancing by one per byte. It continues while the master acknowledges, and it releases SDA for good after a master NACK. The slave changes SDA only while SCL is low.
- R5: Locations 0x00 to 0x07 are the clock registers. A write there produces a strobe carrying index and data, and a read there returns the snapshot. Locations 0x08 to 0x3F are internal RAM and read back the last byte written.
- R6: The pointer advances from 0x3F to 0x00, for both reads and writes.
- R7: The snapshot of the live clock bus is taken at every START, including a repeated START. Changes on the live bus after that START do not alter bytes read before the next START.
- R8: While power-fail is high, SDA is released, the pointer is held at 0x00, and all bus activity, including START, is ignored. A transfer cut by power-fail does not resume.
- R9: After reset SDA is released, no strobe is issued, the RAM reads as zero and the pointer is 0x00.
- R10: A clock-register write strobe lasts exactly one system cycle. It appears together with the slave's acknowledge of that data byte. Address bytes and pointer bytes never produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pwr_fail | input | 1 | Power-fail: abort, zero pointer, ignore bus |
| live_regs | input | 64 | Live clock registers, byte i at bits 8i+7:8i |
| tk_wr_en | output | 1 | One-cycle write strobe to the timekeeper |
| tk_wr_addr | output | 3 | Clock-register index of the write |
| tk_wr_data | output | 8 | Byte written to the clock register |

## Verification
Power-fail and a data-byte commit can overlap. The bench raises power-fail while the slave is still holding the acknowledge for a byte it has just stored. It then checks three things: the byte stays committed, SDA is released within two cycles, and the next read, sent without a pointer byte, starts at location zero. Snapshot capture and a live-bus update are also forced to overlap with one transaction. The live bus changes in the middle of a multi-byte read and again before a repeated START, and the bench checks that each byte matches the value frozen at the START that preceded it. Constrained-random write/read pairs against a reference byte array cover the remaining paths.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int           PTR_W_DEF    = 6;
    localparam int           NUM_CLK_DEF  = 8;
    localparam logic [6:0]   DEV_ADDR_DEF = 7'b1101000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } rx_ph_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
    assign fall = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
    parameter  int PTR_W   = 6,
    parameter  int NUM_CLK = 8,
    localparam int DEPTH   = 1 << PTR_W,
    localparam int RAM_N   = DEPTH - NUM_CLK,
    localparam int CLK_AW  = $clog2(NUM_CLK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   snap_ld,
    input  logic [NUM_CLK*8-1:0]   live_regs,
    input  logic                   wr_vld,
    input  logic [PTR_W-1:0]       wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [PTR_W-1:0]       rd_addr,
    output logic [7:0]             rd_data,
    output logic                   tk_wr_en,
    output logic [CLK_AW-1:0]      tk_wr_addr,
    output logic [7:0]             tk_wr_data
);
    logic [NUM_CLK-1:0][7:0] snap_q;
    logic [7:0]              ram [RAM_N];
    logic                    wr_is_clk;
    logic                    rd_is_clk;

    assign wr_is_clk = wr_addr < PTR_W'(NUM_CLK);
    assign rd_is_clk = rd_addr < PTR_W'(NUM_CLK);

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (snap_ld) snap_q <= live_regs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_N; i++) ram[i] <= '0;
        end else if (wr_vld && !wr_is_clk) begin
            ram[wr_addr - PTR_W'(NUM_CLK)] <= wr_data;
        end
    end

    assign rd_data    = rd_is_clk ? snap_q[rd_addr[CLK_AW-1:0]]
                                  : ram[rd_addr - PTR_W'(NUM_CLK)];
    assign tk_wr_en   = wr_vld & wr_is_clk;
    assign tk_wr_addr = wr_addr[CLK_AW-1:0];
    assign tk_wr_data = wr_data;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !snap_ld |=> $stable(snap_q));                                  // R7

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2cs_pkg::*;
#(
    parameter  logic [6:0] DEV_ADDR    = DEV_ADDR_DEF,
    parameter  int         PTR_W       = PTR_W_DEF,
    parameter  int         NUM_CLK     = NUM_CLK_DEF,
    parameter  int         SYNC_STAGES = 2,
    localparam int         CLK_AW      = $clog2(NUM_CLK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic                  pwr_fail,
    input  logic [NUM_CLK*8-1:0]  live_regs,
    output logic                  tk_wr_en,
    output logic [CLK_AW-1:0]     tk_wr_addr,
    output logic [7:0]            tk_wr_data
);
    bus_ev_t          ev;
    logic             sda_rise, sda_fall;
    bus_st_e          st;
    rx_ph_e           ph;
    logic [3:0]       bcnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic             rd_mode;
    logic             more;
    logic [PTR_W-1:0] ptr;
    logic             oe_q;
    logic             snap_ld;
    logic             wr_vld;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst(rst), .din(scl_in),
        .lvl(ev.scl), .rise(ev.scl_rise), .fall(ev.scl_fall));

    i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst(rst), .din(sda_in),
        .lvl(ev.sda), .rise(sda_rise), .fall(sda_fall));

    assign ev.start = ev.scl & sda_fall;
    assign ev.stop  = ev.scl & sda_rise;

    i2cs_regs #(.PTR_W(PTR_W), .NUM_CLK(NUM_CLK)) u_regs (
        .clk(clk), .rst(rst), .snap_ld(snap_ld), .live_regs(live_regs),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data),
        .tk_wr_en(tk_wr_en), .tk_wr_addr(tk_wr_addr), .tk_wr_data(tk_wr_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; ph <= PH_ADDR; bcnt <= '0; sh <= '0; tx <= '0;
            rd_mode <= 1'b0; more <= 1'b0; ptr <= '0; oe_q <= 1'b0;
            snap_ld <= 1'b0; wr_vld <= 1'b0; wr_addr <= '0; wr_data <= '0;
        end else begin
            wr_vld  <= 1'b0;
            snap_ld <= 1'b0;
            if (pwr_fail) begin
                st <= ST_IDLE; ptr <= '0; oe_q <= 1'b0;
            end else if (ev.start) begin
                st <= ST_RX; ph <= PH_ADDR; bcnt <= '0; oe_q <= 1'b0; snap_ld <= 1'b1;
            end else if (ev.stop) begin
                st <= ST_IDLE; oe_q <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (ev.scl_rise && bcnt < 4'd8) begin
                            sh   <= {sh[6:0], ev.sda};
                            bcnt <= bcnt + 4'd1;
                        end else if (ev.scl_fall && bcnt == 4'd8) begin
                            unique case (ph)
                                PH_ADDR: begin
                                    if (addr_hit(sh, DEV_ADDR)) begin
                                        rd_mode <= sh[0]; oe_q <= 1'b1; st <= ST_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr <= sh[PTR_W-1:0]; oe_q <= 1'b1; st <= ST_ACK;
                                end
                                default: begin
                                    wr_vld <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                                    ptr <= ptr + 1'b1; oe_q <= 1'b1; st <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            bcnt <= '0;
                            if (rd_mode) begin
                                tx <= rd_data; oe_q <= ~rd_data[7];
                                ptr <= ptr + 1'b1; st <= ST_TX;
                            end else begin
                                oe_q <= 1'b0; st <= ST_RX;
                                ph <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bcnt == 4'd7) begin
                                oe_q <= 1'b0; st <= ST_RACK;
                            end else begin
                                tx <= {tx[6:0], 1'b0}; oe_q <= ~tx[6]; bcnt <= bcnt + 4'd1;
                            end
                        end
                    end
                    default: begin
                        if (ev.scl_rise) begin
                            more <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (more) begin
                                tx <= rd_data; oe_q <= ~rd_data[7]; bcnt <= '0;
                                ptr <= ptr + 1'b1; st <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign sda_oe = oe_q;

    AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(oe_q) && !$past(pwr_fail) && !$past(ev.start) && !$past(ev.stop))
            |-> !$past(ev.scl));                                        // R4
    AST_PF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!sda_oe && ptr == '0));                           // R8
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tk_wr_en |=> !tk_wr_en);                                        // R10
    AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        tk_wr_en |-> sda_oe);                                           // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);                                   // R2

endmodule

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        m_scl, m_sda, pwr_fail;
    logic [63:0] live;
    logic        sda_oe, sda_bus;
    logic        tk_wr_en;
    logic [2:0]  tk_wr_addr;
    logic [7:0]  tk_wr_data;

    int checks = 0;
    int errs   = 0;
    int stb_total = 0;
    logic [2:0] stb_a [64];
    logic [7:0] stb_d [64];

    logic [7:0]  mram [64];
    logic [63:0] snap_model;
    logic [5:0]  cur_ptr;
    logic [7:0]  wbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_regslave uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .pwr_fail(pwr_fail), .live_regs(live),
        .tk_wr_en(tk_wr_en), .tk_wr_addr(tk_wr_addr), .tk_wr_data(tk_wr_data));

    always @(posedge clk) begin
        if (tk_wr_en) begin
            stb_a[stb_total % 64] <= tk_wr_addr;
            stb_d[stb_total % 64] <= tk_wr_data;
            stb_total <= stb_total + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [5:0] a);
        return (a < 6'd8) ? snap_model[a*8 +: 8] : mram[a];
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; snap_model = live; tick(8);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(5);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic put_bit(input bit b);
        m_sda = b; tick(5);
        m_scl = 1'b1; tick(10);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(5);
        b = sda_bus; tick(5);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(!mack);
    endtask

    task automatic do_write(input logic [5:0] p, input int n);
        bit ack;
        int base, ne;
        logic [2:0] ea [8];
        logic [7:0] ed [8];
        logic [5:0] a;
        ne = 0;
        bus_start();
        send_byte(8'hD0, ack); chk(ack, "R1 write address ack", ack, 1);
        base = stb_total;
        send_byte({2'b00, p}, ack); chk(ack, "R3 pointer ack", ack, 1);
        a = p;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack); chk(ack, "R3 data ack", ack, 1);
            if (a < 6'd8) begin
                ea[ne] = a[2:0]; ed[ne] = wbuf[k]; ne++;
            end else begin
                mram[a] = wbuf[k];
            end
            a = a + 6'd1;
        end
        bus_stop();
        cur_ptr = a;
        tick(4);
        chk(stb_total - base == ne, "R10 strobe count", stb_total - base, ne);
        for (int j = 0; j < ne; j++) begin
            chk(stb_a[(base+j)%64] == ea[j], "R5 strobe index", stb_a[(base+j)%64], ea[j]);
            chk(stb_d[(base+j)%64] == ed[j], "R5 strobe data", stb_d[(base+j)%64], ed[j]);
        end
        chk(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);
    endtask

    task automatic do_read(input logic [5:0] p, input int n, input bit setp, input int bump);
        bit ack;
        logic [7:0] b;
        if (setp) begin
            bus_start();
            send_byte(8'hD0, ack); chk(ack, "R1 address ack before read", ack, 1);
            send_byte({2'b00, p}, ack); chk(ack, "R3 pointer ack before read", ack, 1);
            cur_ptr = p;
        end
        bus_start();
        send_byte(8'hD1, ack); chk(ack, "R1 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n-1, b);
            chk(b == exp_byte(cur_ptr), "R4 read data", b, exp_byte(cur_ptr));
            cur_ptr = cur_ptr + 6'd1;
            if (k == bump) live = {$urandom, $urandom};
        end
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        bit ack, b;
        logic [5:0] p;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mram[i] = 8'h00;
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1; pwr_fail = 1'b0;
        live = 64'h0123_4567_89AB_CDEF;
        cur_ptr = '0; snap_model = '0;
        tick(6);
        rst = 1'b0;
        tick(4);
        chk(sda_oe == 1'b0, "R9 reset SDA released", sda_oe, 0);
        chk(tk_wr_en == 1'b0, "R9 reset no strobe", tk_wr_en, 0);
        do_read(6'h08, 2, 1'b1, -1);

        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h00; wbuf[3] = 8'hFF;
        do_write(6'h10, 4);
        do_read(6'h10, 4, 1'b1, -1);

        wbuf[0] = 8'h59; wbuf[1] = 8'h07; wbuf[2] = 8'h23;
        do_write(6'h05, 3);

        wbuf[0] = 8'h77;
        do_write(6'h12, 1);
        do_read(6'h00, 1, 1'b0, -1);

        live = {$urandom, $urandom};
        do_read(6'h00, 8, 1'b1, 2);
        do_read(6'h00, 8, 1'b1, -1);

        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
        do_write(6'h3E, 3);
        do_read(6'h3F, 2, 1'b1, -1);
        chk(cur_ptr == 6'h01, "R6 pointer wrap", cur_ptr, 1);

        bus_start();
        send_byte(8'hA2, ack); chk(!ack, "R1 foreign address not acked", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R1 byte after mismatch not acked", ack, 0);
        send_byte(8'h55, ack); chk(!ack, "R1 data after mismatch not acked", ack, 0);
        bus_stop();
        do_read(6'h10, 1, 1'b1, -1);

        bus_start();
        send_byte(8'hD1, ack); chk(ack, "R1 read address ack", ack, 1);
        recv_byte(1'b0, wbuf[7]);
        chk(wbuf[7] == exp_byte(cur_ptr), "R4 read data before NACK", wbuf[7], exp_byte(cur_ptr));
        cur_ptr = cur_ptr + 6'd1;
        get_bit(b); chk(b == 1'b1, "R4 SDA released after NACK", b, 1);
        get_bit(b); chk(b == 1'b1, "R4 SDA stays released", b, 1);
        bus_stop();

        bus_start();
        send_byte(8'hD0, ack); chk(ack, "R1 address ack", ack, 1);
        send_byte(8'h20, ack); chk(ack, "R3 pointer ack", ack, 1);
        for (int i = 7; i >= 0; i--) put_bit(8'h11 >> i);
        chk(sda_oe == 1'b1, "R3 slave drives ack", sda_oe, 1);
        mram[6'h20] = 8'h11;
        pwr_fail = 1'b1;
        tick(2);
        chk(sda_oe == 1'b0, "R8 power-fail releases SDA", sda_oe, 0);
        get_bit(b);
        bus_stop();
        bus_start();
        send_byte(8'hD0, ack); chk(!ack, "R8 bus ignored in power-fail", ack, 0);
        send_byte(8'h30, ack); chk(!ack, "R8 pointer ignored in power-fail", ack, 0);
        send_byte(8'h99, ack); chk(!ack, "R8 data ignored in power-fail", ack, 0);
        bus_stop();
        pwr_fail = 1'b0;
        tick(4);
        cur_ptr = 6'h00;
        do_read(6'h00, 1, 1'b0, -1);
        do_read(6'h20, 1, 1'b1, -1);
        do_read(6'h30, 1, 1'b1, -1);

        for (int it = 0; it < 16; it++) begin
            p = 6'(8 + ($urandom % 52));
            n = 1 + ($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(p, n);
            do_read(p, n, 1'b1, -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule